// File: doc/BRIEF.md
# Framed SPI Register Access Master

This block lets on-chip logic read and write 16-bit registers in an external converter over a single SPI link. The host presents a 15-bit register address, 16 bits of write data and a direction bit, then pulses a request while the block is idle. The block runs one frame of four bytes with chip select held low. At the end it raises a one-cycle done pulse. On reads, the returned word is available on the same cycle as done.

The serial clock idles low. The block drives a new data bit on each rising edge and samples the input line on each falling edge, most significant bit first. A frame always starts with a 16-bit command word whose top bit marks a read. A write then sends the data word. A read sends two all-ones filler bytes, and the two bytes received during them form the result. The half-period of the serial clock is set by a prescaler input.

On leaving reset the block first sends a run of all-ones bytes with chip select high, so that the slave's clock line has settled before any real access. It reports busy until that run has finished.

Top module: `spi_reg_master`

## Requirements
- R1: While reset is asserted and before the first clock edge after it: cs_n=1, sclk=0, mosi=0, done=0, rdata=0, busy=1.
- R2: After reset the block sends FLUSH_BYTES (default 10) bytes of all ones, meaning 8*FLUSH_BYTES sclk pulses, with cs_n held at 1. It then becomes idle, with busy=0.
- R3: sclk is 0 whenever the block is idle. Each sclk level lasts exactly clk_div+1 clock cycles.
- R4: mosi changes only on the cycle in which sclk rises. miso is sampled at sclk falling edges. Bits go MSB first.
- R5: A write (rnw=0) sends {0, addr[14:0]} and then wdata[15:0] as a 32-bit stream, MSB first.
- R6: A read (rnw=1) sends {1, addr[14:0]} and then 16'hFFFF. rdata becomes the last 16 bits sampled from miso, with the first of those 16 bits in rdata[15].
- R7: Between bits, between bytes and after a frame, mosi keeps the level of the last bit sent.
- R8: When a request is taken at clock edge E with H=clk_div+1, cs_n goes low after E. The 64 sclk half-periods then follow. cs_n returns high after edge E+65H.
- R9: done is high for exactly the one cycle after edge E+65H. On a read, rdata holds the new word in that cycle. A write leaves rdata unchanged.
- R10: req is ignored while busy=1, which includes the done edge. A req held high is taken on the first edge at which the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| clk_div | input | DIV_W | Half-period of sclk minus one, in clk cycles |
| req | input | 1 | Start an access (taken only while idle) |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | CMD_W-1 | Register address |
| wdata | input | DATA_W | Write data |
| busy | output | 1 | Flush or access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | DATA_W | Last read result |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong half-bit counter or prescaler count shows up on sclk within one half-period, and the cycle-exact reference model flags it on the first misplaced edge. A corrupted shift register or bit order shows up on mosi at the rising edge of the wrong bit. Sampling on the wrong edge leaves mosi correct but gives the wrong rdata at the done cycle. A state machine that leaves hold too early or too late moves cs_n and done by at least one cycle. Because every output is compared on every cycle, none of these faults survives past the frame in which it occurs.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_XFER  = 2'd2,
    ST_HOLD  = 2'd3
  } ctl_state_e;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  half_tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int FRAME_W     = 32,
  parameter int RX_W        = 16,
  parameter int HC_W        = 8,
  parameter int RST_HALVES  = 160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic [HC_W-1:0]    load_halves,
  input  logic               tick,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic [RX_W-1:0]    rx_word,
  output logic               last_half
);
  localparam logic [HC_W-1:0] ONE = HC_W'(1);

  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [RX_W-1:0]    rx_q, rx_d;
  logic [HC_W-1:0]    hc_q, hc_d, tgt_q, tgt_d;
  logic               act_q, act_d, sclk_q, sclk_d, mosi_q, mosi_d;

  assign last_half = act_q && tick && (hc_q == tgt_q - ONE);
  assign sclk      = sclk_q;
  assign mosi      = mosi_q;
  assign rx_word   = rx_q;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    hc_d   = hc_q;
    tgt_d  = tgt_q;
    act_d  = act_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    if (load) begin
      tx_d  = load_word;
      hc_d  = '0;
      tgt_d = load_halves;
      act_d = 1'b1;
    end else if (act_q && tick) begin
      hc_d = hc_q + ONE;
      if (!hc_q[0]) begin
        sclk_d = 1'b1;
        mosi_d = tx_q[FRAME_W-1];
        tx_d   = {tx_q[FRAME_W-2:0], 1'b1};
      end else begin
        sclk_d = 1'b0;
        rx_d   = {rx_q[RX_W-2:0], miso};
      end
      if (last_half) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '1;
      rx_q   <= '0;
      hc_q   <= '0;
      tgt_q  <= HC_W'(RST_HALVES);
      act_q  <= 1'b1;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      hc_q   <= hc_d;
      tgt_q  <= tgt_d;
      act_q  <= act_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
    end
  end

  // R4
  mosi_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sclk_q) |-> $stable(mosi_q));

  // R3
  sclk_rest_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sclk_q);
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 8,
  parameter int FLUSH_BYTES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req,
  input  logic              rnw,
  input  logic [CMD_W-2:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int FRAME_W      = CMD_W + DATA_W;
  localparam int FRAME_HALVES = 2 * FRAME_W;
  localparam int FLUSH_HALVES = 16 * FLUSH_BYTES;
  localparam int HC_MAX       = (FLUSH_HALVES > FRAME_HALVES) ? FLUSH_HALVES : FRAME_HALVES;
  localparam int HC_W         = $clog2(HC_MAX + 1);

  ctl_state_e        st_q, st_d;
  logic              flush_q, flush_d, rnw_q, rnw_d;
  logic              cs_n_q, cs_n_d, done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              tick, last_half, load, tick_en;
  logic [FRAME_W-1:0] load_word;
  logic [DATA_W-1:0] rx_word;

  assign tick_en   = (st_q != ST_IDLE);
  assign load      = (st_q == ST_IDLE) && req;
  assign load_word = {rnw, addr, (rnw ? {DATA_W{1'b1}} : wdata)};

  spi_half_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tick_en),
    .div  (clk_div),
    .tick (tick)
  );

  spi_shift_core #(
    .FRAME_W   (FRAME_W),
    .RX_W      (DATA_W),
    .HC_W      (HC_W),
    .RST_HALVES(FLUSH_HALVES)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_word  (load_word),
    .load_halves(HC_W'(FRAME_HALVES)),
    .tick       (tick),
    .miso       (miso),
    .sclk       (sclk),
    .mosi       (mosi),
    .rx_word    (rx_word),
    .last_half  (last_half)
  );

  always_comb begin
    st_d    = st_q;
    flush_d = flush_q;
    rnw_d   = rnw_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    rdata_d = rdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d   = ST_XFER;
          cs_n_d = 1'b0;
          rnw_d  = rnw;
        end
      end
      ST_FLUSH, ST_XFER: begin
        if (last_half) st_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (tick) begin
          st_d    = ST_IDLE;
          cs_n_d  = 1'b1;
          done_d  = !flush_q;
          flush_d = 1'b0;
          if (rnw_q && !flush_q) rdata_d = rx_word;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_FLUSH;
      flush_q <= 1'b1;
      rnw_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      flush_q <= flush_d;
      rnw_q   <= rnw_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign busy  = tick_en;
  assign done  = done_q;
  assign rdata = rdata_q;
  assign cs_n  = cs_n_q;

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  flush_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> cs_n_q);

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> done_q);

  // R8
  cs_low_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER) |-> !cs_n_q);

  // R10
  busy_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(rnw_q));
endmodule

// File: tb/spi_reg_master_tb.sv
module spi_reg_master_tb;
  logic        clk;
  logic        rst_n;
  logic [7:0]  clk_div;
  logic        req, rnw, miso;
  logic [14:0] addr;
  logic [15:0] wdata;
  logic        busy, done, sclk, mosi, cs_n;
  logic [15:0] rdata;

  spi_reg_master u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req(req), .rnw(rnw),
    .addr(addr), .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // slave: shifts a response word out MSB first on rising sclk
  logic [31:0] sl_word;
  int          sl_idx;
  initial begin miso = 1'b0; sl_word = '0; sl_idx = 0; end
  always @(negedge cs_n) sl_idx = 0;
  always @(posedge sclk) begin
    if (!cs_n && sl_idx < 32) begin
      miso = sl_word[31 - sl_idx];
      sl_idx++;
    end
  end

  // behavioural reference model
  int          ecount = 0;
  bit          m_act = 1, m_flush = 1, m_rd = 0, m_was_flush = 1;
  int          m_s = 0, m_N = 160, m_H = 2, m_end = -10;
  logic [31:0] m_frame = '0, m_resp = '0;
  logic        m_prev = 1'b0;
  logic [15:0] m_rdata = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      ecount++;
      if (!m_act && req) begin
        m_act = 1; m_flush = 0; m_s = ecount; m_N = 64; m_H = clk_div + 1;
        m_rd = rnw; m_frame = {rnw, addr, (rnw ? 16'hFFFF : wdata)};
        m_resp = sl_word;
      end else if (m_act && (ecount - m_s == (m_N + 1) * m_H)) begin
        m_act = 0; m_end = ecount; m_was_flush = m_flush;
        m_prev = m_flush ? 1'b1 : m_frame[0];
        if (!m_flush && m_rd) m_rdata = m_resp[15:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at edge %0d: actual %h expected %h", tag, ecount, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int n, h;
    logic e_busy, e_cs, e_sclk, e_mosi, e_done;
    if (m_act) begin
      n = ecount - m_s;
      h = n / m_H;
      e_busy = 1'b1;
      e_cs   = m_flush ? 1'b1 : 1'b0;
      e_sclk = (h % 2) == 1;
      e_done = 1'b0;
      if (h == 0)       e_mosi = m_prev;
      else if (m_flush) e_mosi = 1'b1;
      else              e_mosi = m_frame[31 - (h - 1) / 2];
    end else begin
      e_busy = 1'b0; e_cs = 1'b1; e_sclk = 1'b0; e_mosi = m_prev;
      e_done = (ecount == m_end) && !m_was_flush;
    end
    if (ecount == 0) begin
      // R1 reset state
      chk("R1 cs_n", cs_n, 1); chk("R1 sclk", sclk, 0); chk("R1 mosi", mosi, 0);
      chk("R1 done", done, 0); chk("R1 rdata", rdata, 0); chk("R1 busy", busy, 1);
    end else begin
      chk("R10 busy", busy, e_busy);
      chk(m_flush ? "R2 cs_n" : "R8 cs_n", cs_n, e_cs);
      chk(m_flush ? "R2 sclk" : "R3 sclk", sclk, e_sclk);
      chk(m_flush ? "R2 mosi" : (m_rd ? "R4/R6/R7 mosi" : "R4/R5/R7 mosi"), mosi, e_mosi);
      chk("R9 done", done, e_done);
      chk("R6/R9 rdata", rdata, m_rdata);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_act) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic access(input logic r, input logic [14:0] a, input logic [15:0] d,
                        input logic [31:0] resp);
    @(negedge clk);
    sl_word = resp; rnw = r; addr = a; wdata = d; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; rnw = 1'b0; addr = '0; wdata = '0; clk_div = 8'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_idle();                                          // R2 flush
    access(1'b0, 15'h0123, 16'hBEEF, 32'h0);              // R5 write
    access(1'b1, 15'h7F0F, 16'h0000, 32'h0000_C3A5);      // R6 read
    access(1'b0, 15'h0FF0, 16'h8000, 32'hFFFF_FFFF);      // R9 write keeps rdata
    clk_div = 8'd0;
    access(1'b0, 15'h5555, 16'h0001, 32'h0);              // R3 fastest rate
    access(1'b1, 15'h0001, 16'h0000, 32'hFFFF_8001);
    clk_div = 8'd3;
    // R10: requests during a frame are ignored
    @(negedge clk);
    sl_word = 32'h0000_5A3C; rnw = 1'b1; addr = 15'h2468; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    rnw = 1'b0; addr = 15'h7777; wdata = 16'h1111; req = 1'b1;
    repeat (3) @(negedge clk);
    req = 1'b0;
    wait_idle();
    // R10: req held high through the done edge, taken once idle
    @(negedge clk);
    sl_word = 32'h0000_0F0F; rnw = 1'b1; addr = 15'h1357; req = 1'b1;
    @(negedge clk);
    while (m_act) @(negedge clk);
    while (!m_act) @(negedge clk);
    req = 1'b0;
    wait_idle();
    clk_div = 8'd31;
    access(1'b1, 15'h4000, 16'h0000, 32'h1234_A55A);      // R3 slow rate
    summary();
    $finish;
  end
endmodule